// File: doc/BRIEF.md
# Time-Slotted Shared Word RAM Arbiter

This block lets four masters share a single-port 128 x 32 data RAM: a sample filter, a real-time monitor, a compute engine and a byte-wide host processor. A free-running wheel of four cycles gives a reserved slot to the filter, the monitor and the host, in that order, followed by one slot that always belongs to the engine. Because each reserved master only touches the RAM in its own slot, these masters never collide. The engine also takes over any reserved slot whose owner is not using it.

The host works one byte at a time. Its byte writes are collected in a holding register, and the full 32-bit word goes to the RAM when the most significant byte arrives. A read of the least significant byte fetches the whole word into a snapshot register, and the other three bytes are then read from that snapshot. While a host transfer waits for the host slot, the ready output is held low. By convention the analog front end stores its results at fixed words: current and voltage of branch A at words 0 and 1, the same pair for branch B at words 2 and 3, temperature at word 6 and supply monitor at word 7. Words 4 and 5 are left free.

Top module: `slot_ram_arbiter`

## Requirements
- R1: `slot` is 0 in the first cycle after reset and advances by one every cycle, wrapping from 3 to 0. Slot 0 belongs to the filter, 1 to the monitor, 2 to the host and 3 to the engine.
- R2: A filter request acts on the RAM only in a cycle where `slot` is 0. A read there raises `flt_rvalid` in the next cycle. A filter request in any other slot has no effect on the RAM or on any output.
- R3: A monitor request acts only in a cycle where `slot` is 1, and a read raises `mon_rvalid` in the next cycle. A monitor request in any other slot has no effect.
- R4: `eng_gnt` is high in the same cycle exactly when `eng_req` is high and no reserved owner is using that slot. Slot 3 always grants a requesting engine. A granted engine read raises `eng_rvalid` in the next cycle.
- R5: After reset `hst_ready` is 1, `hst_rdata` is 0, all read-valid outputs are 0 and `slot` is 0.
- R6: `hst_addr[8:2]` selects the word and `hst_addr[1:0]` selects the byte lane (0 = bits 7:0, 3 = bits 31:24). A host write to lane 0, 1 or 2 updates only the holding register. It leaves the RAM unchanged and keeps `hst_ready` high.
- R7: A host write to lane 3 stores {lane 3 byte, held lanes 2, 1, 0} into the addressed word in the first host slot after the request. `hst_ready` is low from the cycle after the request through that slot and high in the cycle after it.
- R8: A host read of lane 0 drops `hst_ready` in the next cycle and reads the word in the first host slot after the request. Two cycles after that slot, `hst_ready` is high again and `hst_rdata` holds bits 7:0 of the word.
- R9: A host read of lane 1, 2 or 3 returns the matching byte of the snapshot taken by the last lane-0 read in the next cycle. It keeps `hst_ready` high and does not see later RAM writes.
- R10: A host request made while `hst_ready` is low is ignored.
- R11: During any cycle where a read-valid output is high, `rd_data` holds the word most recently written to the address that was read. At most one read-valid output is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot | output | 2 | Current slot of the wheel |
| flt_req | input | 1 | Filter access request |
| flt_we | input | 1 | Filter write enable |
| flt_addr | input | 7 | Filter word address |
| flt_wdata | input | 32 | Filter write data |
| flt_rvalid | output | 1 | Filter read data valid on rd_data |
| mon_req | input | 1 | Monitor access request |
| mon_we | input | 1 | Monitor write enable |
| mon_addr | input | 7 | Monitor word address |
| mon_wdata | input | 32 | Monitor write data |
| mon_rvalid | output | 1 | Monitor read data valid on rd_data |
| eng_req | input | 1 | Engine access request |
| eng_we | input | 1 | Engine write enable |
| eng_addr | input | 7 | Engine word address |
| eng_wdata | input | 32 | Engine write data |
| eng_gnt | output | 1 | Engine access taken this cycle |
| eng_rvalid | output | 1 | Engine read data valid on rd_data |
| rd_data | output | 32 | Shared RAM read data |
| hst_req | input | 1 | Host byte access request |
| hst_we | input | 1 | Host write enable |
| hst_addr | input | 9 | Host byte address: word in 8:2, lane in 1:0 |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte |
| hst_ready | output | 1 | Host may issue a request |

## Verification
Two kinds of contention can land in the same cycle. The first is a pending host commit or fetch reaching slot 2 while the engine is requesting. The second is a filter or monitor request in its own slot while the engine is requesting. In both cases the reserved owner must take the RAM and `eng_gnt` must stay low. The bench causes both by holding the engine request steady through host transfers and reserved-slot traffic, both in directed runs and in a pseudo-random mix. A behavioural model predicts, for every cycle, the grant, the read-valid strobes, the shared read word and the host ready/byte outputs, and the bench compares the design against it.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int SLOT_W = 2;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_FLT = 2'd0,
    SLOT_MON = 2'd1,
    SLOT_HST = 2'd2,
    SLOT_ENG = 2'd3
  } slot_e;

  // fixed word locations of front-end conversion results
  localparam int WORD_CUR_A  = 0;
  localparam int WORD_VOLT_A = 1;
  localparam int WORD_CUR_B  = 2;
  localparam int WORD_VOLT_B = 3;
  localparam int WORD_TEMP   = 6;
  localparam int WORD_VBAT   = 7;
endpackage

// File: rtl/sra_slot_wheel.sv
module sra_slot_wheel
  import sra_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output slot_e slot_o
);
  always_ff @(posedge clk) begin
    if (rst) slot_o <= SLOT_FLT;
    else     slot_o <= slot_e'(slot_o + 2'd1);
  end
endmodule

// File: rtl/sra_word_ram.sv
module sra_word_ram #(
  parameter int AW = 7,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/sra_host_bridge.sv
module sra_host_bridge #(
  parameter int AW = 7,
  parameter int DW = 32,
  parameter int BW = 8,
  localparam int LANES = DW / BW,
  localparam int LW = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW+LW-1:0] addr_i,
  input  logic [BW-1:0]    wdata_i,
  output logic [BW-1:0]    rdata_o,
  output logic             ready_o,
  input  logic             own_slot_i,
  input  logic [DW-1:0]    ram_rdata_i,
  output logic             acc_req_o,
  output logic             acc_we_o,
  output logic [AW-1:0]    acc_addr_o,
  output logic [DW-1:0]    acc_wdata_o
);
  logic [LANES-1:0][BW-1:0] hold_q;
  logic [LANES-1:0][BW-1:0] snap_q;
  logic                     pend_wr_q, pend_rd_q, cap_q;
  logic [AW-1:0]            addr_q;
  logic [LW-1:0]            lane;
  logic [AW-1:0]            word;
  logic                     take;

  assign lane = addr_i[LW-1:0];
  assign word = addr_i[AW+LW-1:LW];
  assign take = req_i && ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      snap_q    <= '0;
      pend_wr_q <= 1'b0;
      pend_rd_q <= 1'b0;
      cap_q     <= 1'b0;
      addr_q    <= '0;
      ready_o   <= 1'b1;
      rdata_o   <= '0;
    end else begin
      if (take) begin
        if (we_i) begin
          hold_q[lane] <= wdata_i;
          if (lane == LW'(LANES-1)) begin
            pend_wr_q <= 1'b1;
            addr_q    <= word;
            ready_o   <= 1'b0;
          end
        end else if (lane == '0) begin
          pend_rd_q <= 1'b1;
          addr_q    <= word;
          ready_o   <= 1'b0;
        end else begin
          rdata_o <= snap_q[lane];
        end
      end
      if (own_slot_i && pend_wr_q) begin
        pend_wr_q <= 1'b0;
        ready_o   <= 1'b1;
      end
      if (own_slot_i && pend_rd_q) begin
        pend_rd_q <= 1'b0;
        cap_q     <= 1'b1;
      end
      if (cap_q) begin
        cap_q   <= 1'b0;
        snap_q  <= ram_rdata_i;
        rdata_o <= ram_rdata_i[BW-1:0];
        ready_o <= 1'b1;
      end
    end
  end

  assign acc_req_o   = pend_wr_q | pend_rd_q;
  assign acc_we_o    = pend_wr_q;
  assign acc_addr_o  = addr_q;
  assign acc_wdata_o = hold_q;
endmodule

// File: rtl/slot_ram_arbiter.sv
module slot_ram_arbiter
  import sra_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 32,
  parameter int BW = 8,
  localparam int LW = $clog2(DW / BW)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [1:0]       slot,
  input  logic             flt_req,
  input  logic             flt_we,
  input  logic [AW-1:0]    flt_addr,
  input  logic [DW-1:0]    flt_wdata,
  output logic             flt_rvalid,
  input  logic             mon_req,
  input  logic             mon_we,
  input  logic [AW-1:0]    mon_addr,
  input  logic [DW-1:0]    mon_wdata,
  output logic             mon_rvalid,
  input  logic             eng_req,
  input  logic             eng_we,
  input  logic [AW-1:0]    eng_addr,
  input  logic [DW-1:0]    eng_wdata,
  output logic             eng_gnt,
  output logic             eng_rvalid,
  output logic [DW-1:0]    rd_data,
  input  logic             hst_req,
  input  logic             hst_we,
  input  logic [AW+LW-1:0] hst_addr,
  input  logic [BW-1:0]    hst_wdata,
  output logic [BW-1:0]    hst_rdata,
  output logic             hst_ready
);
  slot_e         slot_q;
  logic          hb_req, hb_we;
  logic [AW-1:0] hb_addr;
  logic [DW-1:0] hb_wdata;
  logic          flt_win, mon_win, hst_win, eng_win;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;

  sra_slot_wheel wheel_i (
    .clk    (clk),
    .rst    (rst),
    .slot_o (slot_q)
  );

  sra_host_bridge #(.AW(AW), .DW(DW), .BW(BW)) bridge_i (
    .clk         (clk),
    .rst         (rst),
    .req_i       (hst_req),
    .we_i        (hst_we),
    .addr_i      (hst_addr),
    .wdata_i     (hst_wdata),
    .rdata_o     (hst_rdata),
    .ready_o     (hst_ready),
    .own_slot_i  (slot_q == SLOT_HST),
    .ram_rdata_i (rd_data),
    .acc_req_o   (hb_req),
    .acc_we_o    (hb_we),
    .acc_addr_o  (hb_addr),
    .acc_wdata_o (hb_wdata)
  );

  assign flt_win = (slot_q == SLOT_FLT) && flt_req;
  assign mon_win = (slot_q == SLOT_MON) && mon_req;
  assign hst_win = (slot_q == SLOT_HST) && hb_req;
  assign eng_win = eng_req && !(flt_win || mon_win || hst_win);
  assign eng_gnt = eng_win;
  assign slot    = slot_q;

  always_comb begin
    ram_en    = 1'b1;
    ram_we    = 1'b0;
    ram_addr  = '0;
    ram_wdata = '0;
    if (flt_win) begin
      ram_we = flt_we; ram_addr = flt_addr; ram_wdata = flt_wdata;
    end else if (mon_win) begin
      ram_we = mon_we; ram_addr = mon_addr; ram_wdata = mon_wdata;
    end else if (hst_win) begin
      ram_we = hb_we;  ram_addr = hb_addr;  ram_wdata = hb_wdata;
    end else if (eng_win) begin
      ram_we = eng_we; ram_addr = eng_addr; ram_wdata = eng_wdata;
    end else begin
      ram_en = 1'b0;
    end
  end

  sra_word_ram #(.AW(AW), .DW(DW)) ram_i (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_rvalid <= 1'b0;
      mon_rvalid <= 1'b0;
      eng_rvalid <= 1'b0;
    end else begin
      flt_rvalid <= flt_win && !flt_we;
      mon_rvalid <= mon_win && !mon_we;
      eng_rvalid <= eng_win && !eng_we;
    end
  end
endmodule

// File: rtl/slot_ram_arbiter_chk.sv
module slot_ram_arbiter_chk #(
  parameter int AW = 7,
  parameter int LW = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       slot,
  input logic             flt_req,
  input logic             flt_we,
  input logic             flt_rvalid,
  input logic             mon_req,
  input logic             mon_we,
  input logic             mon_rvalid,
  input logic             eng_req,
  input logic             eng_gnt,
  input logic             eng_rvalid,
  input logic             hst_req,
  input logic             hst_we,
  input logic [AW+LW-1:0] hst_addr,
  input logic             hst_ready
);
  assert_wheel_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (slot == 2'($past(slot) + 2'd1)));

  assert_flt_read_R2: assert property (@(posedge clk) disable iff (rst)
    (slot == 2'd0 && flt_req && !flt_we) |=> flt_rvalid);

  assert_flt_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !(slot == 2'd0 && flt_req && !flt_we) |=> !flt_rvalid);

  assert_mon_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !(slot == 2'd1 && mon_req && !mon_we) |=> !mon_rvalid);

  assert_eng_yield_R4: assert property (@(posedge clk) disable iff (rst)
    (slot == 2'd0 && flt_req) |-> !eng_gnt);

  assert_eng_own_slot_R4: assert property (@(posedge clk) disable iff (rst)
    (slot == 2'd3 && eng_req) |-> eng_gnt);

  assert_lsb_fetch_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (hst_req && hst_ready && !hst_we && hst_addr[LW-1:0] == '0) |=> !hst_ready);

  assert_ready_return_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(hst_ready) |-> (slot == 2'd3 || slot == 2'd0));

  assert_one_reader_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flt_rvalid, mon_rvalid, eng_rvalid}));
endmodule

bind slot_ram_arbiter slot_ram_arbiter_chk #(.AW(AW), .LW(LW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .slot       (slot),
  .flt_req    (flt_req),
  .flt_we     (flt_we),
  .flt_rvalid (flt_rvalid),
  .mon_req    (mon_req),
  .mon_we     (mon_we),
  .mon_rvalid (mon_rvalid),
  .eng_req    (eng_req),
  .eng_gnt    (eng_gnt),
  .eng_rvalid (eng_rvalid),
  .hst_req    (hst_req),
  .hst_we     (hst_we),
  .hst_addr   (hst_addr),
  .hst_ready  (hst_ready)
);

// File: tb/slot_ram_arbiter_tb_top.sv
module slot_ram_arbiter_tb_top;
  import sra_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;
  localparam int DW = 32;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    slot;
  logic          flt_req, flt_we, flt_rvalid;
  logic [AW-1:0] flt_addr;
  logic [DW-1:0] flt_wdata;
  logic          mon_req, mon_we, mon_rvalid;
  logic [AW-1:0] mon_addr;
  logic [DW-1:0] mon_wdata;
  logic          eng_req, eng_we, eng_gnt, eng_rvalid;
  logic [AW-1:0] eng_addr;
  logic [DW-1:0] eng_wdata;
  logic [DW-1:0] rd_data;
  logic          hst_req, hst_we, hst_ready;
  logic [AW+1:0] hst_addr;
  logic [BW-1:0] hst_wdata, hst_rdata;

  slot_ram_arbiter #(.AW(AW), .DW(DW), .BW(BW)) dut_i (
    .clk(clk), .rst(rst), .slot(slot),
    .flt_req(flt_req), .flt_we(flt_we), .flt_addr(flt_addr),
    .flt_wdata(flt_wdata), .flt_rvalid(flt_rvalid),
    .mon_req(mon_req), .mon_we(mon_we), .mon_addr(mon_addr),
    .mon_wdata(mon_wdata), .mon_rvalid(mon_rvalid),
    .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_gnt(eng_gnt), .eng_rvalid(eng_rvalid),
    .rd_data(rd_data),
    .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_ready(hst_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [31:0] mm [0:127];
  logic [7:0]  mh [0:3];
  int          m_slot, m_paddr;
  bit          m_frv, m_mrv, m_erv, m_ready, m_pwr, m_prd, m_cap, exp_gnt;
  logic [31:0] m_dout, m_snap;
  logic [7:0]  m_rdata;
  int          ncyc = 0, n_chk = 0, n_fail = 0;
  string       scen = "reset";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s) t=%0t: actual %h expected %h", tag, scen, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_slot = 0; m_frv = 0; m_mrv = 0; m_erv = 0; m_ready = 1;
    m_pwr = 0; m_prd = 0; m_cap = 0; m_paddr = 0; m_rdata = 8'h00; m_snap = 32'h0;
    for (int i = 0; i < 4; i++) mh[i] = 8'h00;
  endtask

  task automatic model_edge();
    bit fw, mw, hw, eg, rdy0;
    fw = (m_slot == 0) && flt_req;
    mw = (m_slot == 1) && mon_req;
    hw = (m_slot == 2) && (m_pwr || m_prd);
    eg = eng_req && !(fw || mw || hw);
    rdy0 = m_ready;
    if (m_cap) begin
      m_snap = m_dout; m_rdata = m_dout[7:0]; m_ready = 1; m_cap = 0;
    end
    m_frv = fw && !flt_we;
    m_mrv = mw && !mon_we;
    m_erv = eg && !eng_we;
    if (fw) begin if (flt_we) mm[flt_addr] = flt_wdata; else m_dout = mm[flt_addr]; end
    if (mw) begin if (mon_we) mm[mon_addr] = mon_wdata; else m_dout = mm[mon_addr]; end
    if (hw) begin
      if (m_pwr) begin
        mm[m_paddr] = {mh[3], mh[2], mh[1], mh[0]}; m_pwr = 0; m_ready = 1;
      end else begin
        m_dout = mm[m_paddr]; m_prd = 0; m_cap = 1;
      end
    end
    if (eg) begin if (eng_we) mm[eng_addr] = eng_wdata; else m_dout = mm[eng_addr]; end
    if (hst_req && rdy0) begin
      if (hst_we) begin
        mh[hst_addr[1:0]] = hst_wdata;
        if (hst_addr[1:0] == 2'd3) begin m_pwr = 1; m_paddr = int'(hst_addr[8:2]); m_ready = 0; end
      end else if (hst_addr[1:0] == 2'd0) begin
        m_prd = 1; m_paddr = int'(hst_addr[8:2]); m_ready = 0;
      end else begin
        m_rdata = m_snap[8*hst_addr[1:0] +: 8];
      end
    end
    m_slot = (m_slot + 1) % 4;
  endtask

  // one clock: compare registered outputs, then the grant, then advance the model
  task automatic step();
    bit fw, mw, hw;
    if (ncyc > 0) begin
      chk(slot === 2'(m_slot), "R1 slot", 32'(slot), 32'(m_slot));
      chk(flt_rvalid === m_frv, "R2 flt_rvalid", 32'(flt_rvalid), 32'(m_frv));
      chk(mon_rvalid === m_mrv, "R3 mon_rvalid", 32'(mon_rvalid), 32'(m_mrv));
      chk(eng_rvalid === m_erv, "R4 eng_rvalid", 32'(eng_rvalid), 32'(m_erv));
      chk(hst_ready === m_ready, "R7 R8 R10 hst_ready", 32'(hst_ready), 32'(m_ready));
      chk(hst_rdata === m_rdata, "R8 R9 hst_rdata", 32'(hst_rdata), 32'(m_rdata));
      if (m_frv || m_mrv || m_erv)
        chk(rd_data === m_dout, "R11 rd_data", rd_data, m_dout);
    end
    #1;
    fw = (m_slot == 0) && flt_req;
    mw = (m_slot == 1) && mon_req;
    hw = (m_slot == 2) && (m_pwr || m_prd);
    exp_gnt = eng_req && !(fw || mw || hw);
    if (ncyc > 0 && !rst)
      chk(eng_gnt === exp_gnt, "R4 eng_gnt", 32'(eng_gnt), 32'(exp_gnt));
    @(posedge clk);
    if (rst) model_reset(); else model_edge();
    ncyc++;
    @(negedge clk);
  endtask

  task automatic idle();
    flt_req = 0; mon_req = 0; eng_req = 0; hst_req = 0;
  endtask

  task automatic wait_slot(input int s);
    while (m_slot != s) step();
  endtask

  task automatic flt_op(input bit we, input int a, input logic [31:0] d);
    wait_slot(0);
    flt_req = 1; flt_we = we; flt_addr = AW'(a); flt_wdata = d;
    step(); flt_req = 0;
  endtask

  task automatic mon_op(input bit we, input int a, input logic [31:0] d);
    wait_slot(1);
    mon_req = 1; mon_we = we; mon_addr = AW'(a); mon_wdata = d;
    step(); mon_req = 0;
  endtask

  task automatic eng_op(input bit we, input int a, input logic [31:0] d);
    eng_req = 1; eng_we = we; eng_addr = AW'(a); eng_wdata = d;
    do step(); while (!exp_gnt);
    eng_req = 0;
  endtask

  task automatic host_op(input bit we, input int word, input int lane, input logic [7:0] d);
    hst_req = 1; hst_we = we; hst_addr = {7'(word), 2'(lane)}; hst_wdata = d;
    step(); hst_req = 0;
    while (!m_ready) step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    rst = 1; idle();
    flt_we = 0; flt_addr = '0; flt_wdata = '0;
    mon_we = 0; mon_addr = '0; mon_wdata = '0;
    eng_we = 0; eng_addr = '0; eng_wdata = '0;
    hst_we = 0; hst_addr = '0; hst_wdata = '0;
    model_reset();
    repeat (3) step();
    // R5 reset state
    chk(hst_ready === 1'b1, "R5 hst_ready", 32'(hst_ready), 32'd1);
    chk(hst_rdata === 8'h00, "R5 hst_rdata", 32'(hst_rdata), 32'd0);
    chk({flt_rvalid, mon_rvalid, eng_rvalid} === 3'b000, "R5 rvalid", 32'({flt_rvalid, mon_rvalid, eng_rvalid}), 32'd0);
    chk(slot === 2'd0, "R5 slot", 32'(slot), 32'd0);
    rst = 0;

    scen = "R4 fill";
    for (int w = 0; w < 128; w++) eng_op(1, w, {8'h5A, 8'(w), 8'(~w), 8'(w * 3)});

    scen = "R2 converter words";
    flt_op(1, WORD_CUR_A, 32'h1111_0001);
    flt_op(1, WORD_VOLT_A, 32'h2222_0002);
    flt_op(1, WORD_CUR_B, 32'h3333_0003);
    flt_op(1, WORD_VOLT_B, 32'h4444_0004);
    flt_op(1, WORD_TEMP, 32'h6666_0006);
    flt_op(1, WORD_VBAT, 32'h7777_0007);
    scen = "R3 R11 readback";
    mon_op(0, WORD_CUR_A, 0); mon_op(0, WORD_VOLT_B, 0);
    eng_op(0, WORD_TEMP, 0); flt_op(0, WORD_VBAT, 0);

    scen = "R2 R3 off-slot ignored";
    for (int s = 1; s < 4; s++) begin
      wait_slot(s);
      flt_req = 1; flt_we = 1; flt_addr = 7'd4; flt_wdata = 32'hDEAD_0000 + 32'(s);
      step(); flt_req = 0;
    end
    wait_slot(0);
    mon_req = 1; mon_we = 1; mon_addr = 7'd5; mon_wdata = 32'hBEEF_BEEF;
    step(); mon_req = 0;
    eng_op(0, 4, 0); eng_op(0, 5, 0);

    scen = "R4 contention";
    flt_req = 1; flt_we = 0; flt_addr = 7'd2;
    mon_req = 1; mon_we = 0; mon_addr = 7'd3;
    eng_req = 1; eng_we = 0; eng_addr = 7'd9;
    repeat (9) step();
    idle();

    scen = "R6 partial host write";
    host_op(1, 10, 0, 8'h11); host_op(1, 10, 1, 8'h22); host_op(1, 10, 2, 8'h33);
    eng_op(0, 10, 0);
    scen = "R7 commit under engine load";
    eng_req = 1; eng_we = 0; eng_addr = 7'd11;
    host_op(1, 10, 3, 8'h44);
    idle();
    eng_op(0, 10, 0);

    scen = "R8 lsb fetch";
    host_op(0, 10, 0, 0);
    scen = "R9 snapshot bytes";
    host_op(0, 10, 1, 0); host_op(0, 10, 3, 0);
    eng_op(1, 10, 32'hCAFE_F00D);
    host_op(0, 10, 2, 0);

    scen = "R10 busy host ignored";
    hst_req = 1; hst_we = 1; hst_addr = {7'd12, 2'd3}; hst_wdata = 8'h77;
    step();
    hst_addr = {7'd12, 2'd0}; hst_wdata = 8'hEE; step();
    hst_we = 0; step();
    hst_req = 0;
    while (!m_ready) step();
    host_op(1, 12, 3, 8'h88);
    eng_op(0, 12, 0);

    scen = "R7 R8 request in host slot";
    wait_slot(2); host_op(1, 13, 3, 8'h99);
    wait_slot(2); host_op(0, 13, 0, 0);
    wait_slot(1); host_op(0, 12, 0, 0);

    scen = "random mix";
    lf = 32'h1ACE_B00C;
    for (int c = 0; c < 3000; c++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      flt_req = lf[0]; flt_we = lf[1]; flt_addr = {3'd0, lf[5:2]}; flt_wdata = lf;
      mon_req = lf[6]; mon_we = lf[7]; mon_addr = {3'd0, lf[11:8]}; mon_wdata = ~lf;
      eng_req = lf[12]; eng_we = lf[13]; eng_addr = {3'd0, lf[17:14]}; eng_wdata = {lf[15:0], lf[31:16]};
      hst_req = lf[18] && (m_ready || lf[19]);
      hst_we = lf[20]; hst_addr = {3'd0, lf[24:21], lf[26:25]}; hst_wdata = lf[31:24];
      step();
    end
    idle();
    repeat (8) step();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule